// File: doc/BRIEF.md
# Subcarrier Quadrature Phase Rotator

This block takes a clock that runs at four times the color subcarrier frequency. A twisted-ring (Johnson) counter divides that clock by four, which gives four copies of the subcarrier, each a quarter cycle (90 degrees) away from the next. A selector picks one of these quarter-phase taps. The chosen tap is registered and leaves the block as the feedback subcarrier. The block also reports which tap it is currently using, as a phase index.

Each horizontal line strobe advances the phase index by a step that the video standard sets. The step is half a turn (two taps) for the 525-line standard and a quarter turn (one tap) for the 625-line standard. With this rotation, a sample of the feedback subcarrier taken once per line lands at the same phase on every line. The oscillator that produces the 4x clock, the phase detector and the loop filter sit outside this block.

Top module: `sc_quad_rotator`

## Requirements
- R1: After reset is released, the feedback output has a period of exactly four clock cycles and is high for two consecutive cycles and low for two in each period.
- R2: While `rst` is high at a rising edge, that edge clears `phase_idx` to 0, clears `fb_subcarrier` to 0 and returns the divider to its starting state.
- R3: Let n count the rising edges since reset was released. Let k be the `phase_idx` value held before edge n. After edge n, `fb_subcarrier` is 1 exactly when (n-1-k) mod 4 is 0 or 1. Each increment of k therefore delays the output by one clock cycle, which is 90 degrees of subcarrier.
- R4: With `std_pal` = 0 (525-line standard), a rising edge that sees `line_strobe` high sets `phase_idx` to (previous + 2) mod 4.
- R5: With `std_pal` = 1 (625-line standard), a rising edge that sees `line_strobe` high sets `phase_idx` to (previous + 1) mod 4, wrapping from 3 to 0.
- R6: At any edge without `line_strobe`, `phase_idx` is unchanged. A change of `std_pal` alone has no effect on `phase_idx` or on the output; the new step applies from the next strobe.
- R7: A new `phase_idx` written at edge n is the one the selector uses for the output sampled at edge n+1. The output produced at edge n itself still uses the old index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Clock at four times the subcarrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| line_strobe | input | 1 | One-cycle pulse per horizontal line, synchronous to clk4x |
| std_pal | input | 1 | Video standard: 0 selects a 180-degree step per line, 1 a 90-degree step |
| fb_subcarrier | output | 1 | Registered feedback subcarrier at the selected quarter phase |
| phase_idx | output | 2 | Index of the tap currently selected, 0 to 3 |

## Verification
The hardest case to reach is the seam where the index changes at the same edge that the output register samples the old tap. An off-by-one cycle in the selector would look correct whenever the strobe is rare and the bench looks only at steady state. For that reason the stimulus checks every output bit against the edge count and the index value held before that edge. It places strobes at varying gaps, back to back and across both standards, so that the modulo-4 wraps happen in the middle of a run. Reset is also applied mid-run, after the index has been moved away from zero.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } video_std_e;

   // Taps to advance per line: half a turn or a quarter turn of the ring.
   function automatic int unsigned line_step(video_std_e s, int unsigned nph);
      return (s == STD_625) ? nph / 4 : nph / 2;
   endfunction

endpackage

// File: rtl/sqr_johnson.sv
module sqr_johnson #(
   parameter int unsigned JC_BITS = 2,
   localparam int unsigned NUM_PH = 2 * JC_BITS
) (
   input  logic              clk,
   input  logic              rst,
   output logic [NUM_PH-1:0] taps
);

   logic [JC_BITS-1:0] ring_q;

   if (JC_BITS < 2) begin : g_bad_bits
      $error("sqr_johnson: JC_BITS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) ring_q <= '0;
      else     ring_q <= {ring_q[JC_BITS-2:0], ~ring_q[JC_BITS-1]};
   end

   // Tap k is high for JC_BITS cycles starting k cycles after the all-zero state.
   assign taps[0] = ~ring_q[JC_BITS-1];
   for (genvar k = 1; k <= JC_BITS; k++) begin : g_true_taps
      assign taps[k] = ring_q[k-1];
   end
   for (genvar k = 1; k < JC_BITS; k++) begin : g_inv_taps
      assign taps[JC_BITS+k] = ~ring_q[k-1];
   end

   p_one_bit_step_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $countones(ring_q ^ $past(ring_q)) == 1);

   p_ring_cleared_r2: assert property (@(posedge clk)
      rst |=> ring_q == '0);

endmodule

// File: rtl/sqr_phase_sel.sv
module sqr_phase_sel #(
   parameter int unsigned NUM_PH = 4,
   localparam int unsigned SEL_W = $clog2(NUM_PH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_strobe,
   input  logic             std_pal,
   output logic [SEL_W-1:0] sel
);
   import sqr_pkg::*;

   localparam logic [SEL_W:0] STEP_525 = (SEL_W+1)'(line_step(STD_525, NUM_PH));
   localparam logic [SEL_W:0] STEP_625 = (SEL_W+1)'(line_step(STD_625, NUM_PH));
   localparam logic [SEL_W:0] WRAP     = (SEL_W+1)'(NUM_PH);

   if (NUM_PH % 4 != 0) begin : g_bad_ph
      $error("sqr_phase_sel: NUM_PH must be a multiple of 4");
   end

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_nx;
   logic [SEL_W:0]   sum;

   always_comb begin
      sum = {1'b0, sel_q} + ((video_std_e'(std_pal) == STD_625) ? STEP_625 : STEP_525);
   end

   if (NUM_PH == (1 << SEL_W)) begin : g_pow2_wrap
      assign sel_nx = sum[SEL_W-1:0];
   end else begin : g_cmp_wrap
      assign sel_nx = (sum >= WRAP) ? SEL_W'(sum - WRAP) : sum[SEL_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)              sel_q <= '0;
      else if (line_strobe) sel_q <= sel_nx;
   end

   assign sel = sel_q;

   p_hold_idx_r6: assert property (@(posedge clk) disable iff (rst)
      !line_strobe |=> $stable(sel_q));

   p_half_turn_r4: assert property (@(posedge clk) disable iff (rst)
      (line_strobe && !std_pal) |=>
         sel_q == SEL_W'((int'($past(sel_q)) + NUM_PH / 2) % NUM_PH));

   p_quarter_turn_r5: assert property (@(posedge clk) disable iff (rst)
      (line_strobe && std_pal) |=>
         sel_q == SEL_W'((int'($past(sel_q)) + NUM_PH / 4) % NUM_PH));

endmodule

// File: rtl/sqr_tap_mux.sv
module sqr_tap_mux #(
   parameter int unsigned NUM_PH = 4,
   localparam int unsigned SEL_W = $clog2(NUM_PH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_PH-1:0] taps,
   input  logic [SEL_W-1:0]  sel,
   output logic              fb
);

   logic picked;
   logic fb_q;

   assign picked = taps[sel];

   always_ff @(posedge clk) begin
      if (rst) fb_q <= 1'b0;
      else     fb_q <= picked;
   end

   assign fb = fb_q;

   p_fb_cleared_r2: assert property (@(posedge clk)
      rst |=> !fb_q);

   p_fb_follows_tap_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> fb_q == $past(taps[sel]));

endmodule

// File: rtl/sc_quad_rotator.sv
module sc_quad_rotator #(
   parameter int unsigned JC_BITS = 2,
   localparam int unsigned NUM_PH = 2 * JC_BITS,
   localparam int unsigned SEL_W  = $clog2(NUM_PH)
) (
   input  logic             clk4x,
   input  logic             rst,
   input  logic             line_strobe,
   input  logic             std_pal,
   output logic             fb_subcarrier,
   output logic [SEL_W-1:0] phase_idx
);

   logic [NUM_PH-1:0] taps;
   logic [SEL_W-1:0]  sel;

   sqr_johnson #(.JC_BITS(JC_BITS)) u_ring (
      .clk  (clk4x),
      .rst  (rst),
      .taps (taps)
   );

   sqr_phase_sel #(.NUM_PH(NUM_PH)) u_sel (
      .clk         (clk4x),
      .rst         (rst),
      .line_strobe (line_strobe),
      .std_pal     (std_pal),
      .sel         (sel)
   );

   sqr_tap_mux #(.NUM_PH(NUM_PH)) u_mux (
      .clk  (clk4x),
      .rst  (rst),
      .taps (taps),
      .sel  (sel),
      .fb   (fb_subcarrier)
   );

   assign phase_idx = sel;

   p_idx_cleared_r2: assert property (@(posedge clk4x)
      rst |=> phase_idx == '0);

endmodule

// File: tb/sc_quad_rotator_bench.sv
module sc_quad_rotator_bench;

   logic       clk4x = 1'b0;
   logic       rst = 1'b1;
   logic       line_strobe = 1'b0;
   logic       std_pal = 1'b0;
   logic       fb_subcarrier;
   logic [1:0] phase_idx;

   int checks = 0;
   int failures = 0;
   int n = 0;
   bit done = 1'b0;

   always #5 clk4x = ~clk4x;

   sc_quad_rotator u_sc_quad_rotator (
      .clk4x         (clk4x),
      .rst           (rst),
      .line_strobe   (line_strobe),
      .std_pal       (std_pal),
      .fb_subcarrier (fb_subcarrier),
      .phase_idx     (phase_idx)
   );

   // {std_pal, expected index after the strobe}, starting from index 0
   localparam logic [2:0] VEC [10] = '{
      {1'b0, 2'd2}, {1'b0, 2'd0}, {1'b1, 2'd1}, {1'b1, 2'd2}, {1'b1, 2'd3},
      {1'b1, 2'd0}, {1'b0, 2'd2}, {1'b1, 2'd3}, {1'b0, 2'd1}, {1'b0, 2'd3}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (n=%0d)", req, act, exp, n);
      end
   endtask

   // One clock: drive at the falling edge, sample at the next falling edge.
   task automatic tick(input logic r, input logic s, input logic p);
      int k;
      rst = r;
      line_strobe = s;
      std_pal = p;
      k = int'(phase_idx);
      @(posedge clk4x);
      @(negedge clk4x);
      if (r) begin
         n = 0;
         chk("R2 fb", int'(fb_subcarrier), 0);
         chk("R2 idx", int'(phase_idx), 0);
      end else begin
         n++;
         // R1/R3/R7: the output reflects the index held before this edge
         chk("R3 fb", int'(fb_subcarrier), (((n - 1 - k) % 4 + 4) % 4) < 2 ? 1 : 0);
         if (s) chk(p ? "R5 step" : "R4 step", int'(phase_idx), (k + (p ? 1 : 2)) % 4);
         else   chk("R6 hold", int'(phase_idx), k);
      end
   endtask

   initial begin
      int hi;
      @(negedge clk4x);
      tick(1, 0, 0);
      tick(1, 0, 0);
      // R1: 4-cycle period, 2 high per period at idx 0
      hi = 0;
      for (int c = 0; c < 8; c++) begin
         tick(0, 0, 0);
         hi += int'(fb_subcarrier);
      end
      chk("R1 duty", hi, 4);
      // Table walk: strobes at varying gaps
      for (int i = 0; i < 10; i++) begin
         tick(0, 1, VEC[i][2]);
         chk(VEC[i][2] ? "R5 table" : "R4 table", int'(phase_idx), int'(VEC[i][1:0]));
         for (int g = 0; g < (i % 3) + 1; g++) tick(0, 0, VEC[i][2]);
      end
      // R6: toggling standard without strobe changes nothing
      for (int c = 0; c < 6; c++) tick(0, 0, c[0]);
      chk("R6 idx kept", int'(phase_idx), 3);
      // Back-to-back strobes, R5 wrap 3->0 then R4
      tick(0, 1, 1);
      chk("R5 wrap", int'(phase_idx), 0);
      tick(0, 1, 0);
      tick(0, 1, 0);
      tick(0, 1, 1);
      chk("R7 back-to-back", int'(phase_idx), 1);
      for (int c = 0; c < 5; c++) tick(0, 0, 1);
      // R2: reset mid-run with nonzero index
      tick(1, 0, 0);
      chk("R2 mid-run idx", int'(phase_idx), 0);
      for (int c = 0; c < 6; c++) tick(0, 0, 0);
      tick(0, 1, 1);
      for (int c = 0; c < 6; c++) tick(0, 0, 1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule